// File: doc/BRIEF.md
# Converter Link Transmit Start-up Sequencer

This block decides, cycle by cycle, what every lane of a multi-lane converter transmit link carries after reset. It starts by sending the comma control character K28.5 (0xBC) on all lanes so that the far end can lock its character alignment. Once the combined receiver request line `sync_n` goes high, the block waits for a release boundary and then sends an initial lane alignment pattern lasting four multiframes, followed by user data. A receiver that pulls `sync_n` low again at any later time sends the link back to the K28.5 stream.

The release boundary depends on the subclass input. Subclass 0 releases at the next frame start. Any nonzero subclass releases at the next multiframe start and never at a later one. Two free-running counters measure position: one counts octets within a frame and wraps after `OCT_PER_FRAME` octets, and the other counts frames within a multiframe and wraps after `FRAMES_PER_MF` frames. Both counters are zero in the first cycle after reset. Each lane produces one octet per cycle with a control flag, which feeds a downstream 8b/10b encoder.

Top module: `lane_sync_tx`

## Requirements
- R1: In the first cycle after reset, and in every cycle while in the K28.5 phase, each lane outputs 0xBC with `lane_is_k` high.
- R2: At least four K28.5 cycles are sent after reset before any other octet, even if `sync_n` is high from the start.
- R3: With `subclass` = 0, the K28.5 phase ends on the clock edge that closes the first cycle in which `sync_n` is high, at least four K28.5 cycles have gone out, and the octet index is `OCT_PER_FRAME`-1. The next octet therefore starts a frame.
- R4: With `subclass` nonzero, the K28.5 phase ends at the first cycle meeting the conditions of R3 where the frame index is also `FRAMES_PER_MF`-1. The alignment pattern therefore starts on the first multiframe start after release.
- R5: The alignment pattern lasts 4·F·K octets, where F = `OCT_PER_FRAME` and K = `FRAMES_PER_MF`. With w the octet index within a multiframe and m the multiframe number 0..3, every lane sends:
  - 0x1C (K28.0) with the flag high when w = 0;
  - 0x7C (K28.3) with the flag high when w = F·K-1;
  - 0x9C (K28.4) with the flag high when m = 1 and w = 1;
  - otherwise the value w with the flag low.
- R6: With `subclass` = 0 and `ilas_en` low, the cycle after release carries user data directly, with no alignment pattern.
- R7: With `subclass` nonzero, the alignment pattern is sent whatever the value of `ilas_en`.
- R8: If `sync_n` is low in any cycle during the alignment pattern or user data, the next cycle outputs K28.5 on every lane.
- R9: During user data, lane n outputs `tx_data[8n+7:8n]` in the same cycle with its flag low.
- R10: User data begins in the cycle right after the last alignment octet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_n | input | 1 | Combined receiver synchronization request, active low |
| subclass | input | 2 | 0 releases at a frame boundary; any other value releases at a multiframe boundary |
| ilas_en | input | 1 | Alignment pattern enable; only has an effect when subclass is 0 |
| tx_data | input | LANES*8 | User octets, lane n in bits 8n+7..8n |
| lane_octet | output | LANES*8 | Octet sent on each lane this cycle |
| lane_is_k | output | LANES | Per-lane control-character flag |

## Verification
Lane outputs are decoded from the phase register in the same cycle, so user data appears in the cycle it is driven. A phase change appears in the cycle after the edge that decided it: the release edge, the last alignment octet, or a cycle with `sync_n` low. For each scenario the bench works out the release cycle from the counter arithmetic in R3 and R4. It then pushes one expected item per cycle, immediately after driving that cycle's inputs. The monitor pops and compares each item at the falling edge of the same cycle, so every check lands on the cycle in which its result is due.

// File: rtl/lane_sync_tx.sv
module lane_sync_tx #(
  parameter int LANES         = 2,
  parameter int OCT_PER_FRAME = 2,
  parameter int FRAMES_PER_MF = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_n,
  input  logic [1:0]         subclass,
  input  logic               ilas_en,
  input  logic [LANES*8-1:0] tx_data,
  output logic [LANES*8-1:0] lane_octet,
  output logic [LANES-1:0]   lane_is_k
);
  localparam int MF_LEN = OCT_PER_FRAME * FRAMES_PER_MF;
  localparam int OW = (OCT_PER_FRAME > 1) ? $clog2(OCT_PER_FRAME) : 1;
  localparam int FW = (FRAMES_PER_MF > 1) ? $clog2(FRAMES_PER_MF) : 1;
  localparam int PW = $clog2(MF_LEN);
  localparam logic [7:0] SYM_K = 8'hBC;
  localparam logic [7:0] SYM_R = 8'h1C;
  localparam logic [7:0] SYM_A = 8'h7C;
  localparam logic [7:0] SYM_Q = 8'h9C;

  typedef enum logic [1:0] {CGS, ALIGN, USER} st_t;

  st_t st, st_nx;
  logic [OW-1:0] oct;
  logic [FW-1:0] frm;
  logic [1:0]    kseen;
  logic [PW-1:0] apos;
  logic [1:0]    amf;
  logic [7:0]    abyte;
  logic          ak;

  wire frame_end  = (oct == OW'(OCT_PER_FRAME - 1));
  wire mf_end     = frame_end && (frm == FW'(FRAMES_PER_MF - 1));
  wire at_bound   = (subclass == 2'd0) ? frame_end : mf_end;
  wire align_last = (amf == 2'd3) && (apos == PW'(MF_LEN - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      oct <= '0;
      frm <= '0;
    end else if (frame_end) begin
      oct <= '0;
      frm <= (frm == FW'(FRAMES_PER_MF - 1)) ? '0 : frm + 1'b1;
    end else begin
      oct <= oct + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              kseen <= '0;
    else if (st != CGS)      kseen <= '0;
    else if (kseen != 2'd3)  kseen <= kseen + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      apos <= '0;
      amf  <= '0;
    end else if (st != ALIGN) begin
      apos <= '0;
      amf  <= '0;
    end else if (apos == PW'(MF_LEN - 1)) begin
      apos <= '0;
      amf  <= amf + 1'b1;
    end else begin
      apos <= apos + 1'b1;
    end

  always_comb begin
    st_nx = st;
    case (st)
      CGS:
        if (sync_n && kseen == 2'd3 && at_bound)
          st_nx = (subclass == 2'd0 && !ilas_en) ? USER : ALIGN;
      ALIGN:
        if (!sync_n)         st_nx = CGS;
        else if (align_last) st_nx = USER;
      default:
        if (!sync_n)         st_nx = CGS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= CGS;
    else        st <= st_nx;

  always_comb begin
    abyte = 8'(apos);
    ak    = 1'b0;
    if (apos == '0) begin
      abyte = SYM_R;
      ak    = 1'b1;
    end else if (apos == PW'(MF_LEN - 1)) begin
      abyte = SYM_A;
      ak    = 1'b1;
    end else if (amf == 2'd1 && apos == PW'(1)) begin
      abyte = SYM_Q;
      ak    = 1'b1;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_octet[l*8 +: 8] = (st == USER)  ? tx_data[l*8 +: 8] :
                                  (st == ALIGN) ? abyte : SYM_K;
    assign lane_is_k[l]         = (st == USER)  ? 1'b0 :
                                  (st == ALIGN) ? ak : 1'b1;
  end

  // R8
  resync_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |=> (&lane_is_k && lane_octet == {LANES{SYM_K}}));

  // R2
  min_comma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == CGS && st != CGS) |-> $past(kseen) == 2'd3);

  // R3
  frame_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == CGS && st != CGS && $past(subclass) == 2'd0) |-> oct == '0);

  // R4
  mf_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == CGS && st != CGS && $past(subclass) != 2'd0)
      |-> (oct == '0 && frm == '0 && st == ALIGN));

  // R9
  data_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == USER |-> lane_is_k == '0);

  // R10
  align_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ALIGN && st == USER) |-> ($past(amf) == 2'd3 && $past(apos) == PW'(MF_LEN - 1)));
endmodule

// File: tb/lane_sync_tx_tb.sv
module lane_sync_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LN = 2;
  localparam int F  = 2;
  localparam int K  = 4;
  localparam int MFL = F * K;
  localparam int ALEN = 4 * MFL;

  typedef struct packed {
    logic [LN*8-1:0] oct;
    logic [LN-1:0]   k;
  } item_t;

  logic clk = 0;
  logic rst_n = 0;
  logic sync_n = 0;
  logic [1:0] subclass = 0;
  logic ilas_en = 0;
  logic [LN*8-1:0] tx_data = 0;
  logic [LN*8-1:0] lane_octet;
  logic [LN-1:0] lane_is_k;

  item_t exp_q[$];
  string tag_q[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_sync_tx #(.LANES(LN), .OCT_PER_FRAME(F), .FRAMES_PER_MF(K)) u_dut (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .subclass(subclass),
    .ilas_en(ilas_en), .tx_data(tx_data),
    .lane_octet(lane_octet), .lane_is_k(lane_is_k)
  );

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      item_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (lane_octet !== e.oct || lane_is_k !== e.k) begin
        fails++;
        $display("FAIL %s: got octets=%h k=%b expected octets=%h k=%b",
                 t, lane_octet, lane_is_k, e.oct, e.k);
      end
    end
  end

  function automatic bit is_bound(int c, logic [1:0] sc);
    if (sc == 2'd0) return (c % F) == F - 1;
    return (c % MFL) == MFL - 1;
  endfunction

  function automatic logic [8:0] align_sym(int i);
    int w = i % MFL;
    int m = i / MFL;
    if (w == 0)              return {1'b1, 8'h1C};
    if (w == MFL - 1)        return {1'b1, 8'h7C};
    if (m == 1 && w == 1)    return {1'b1, 8'h9C};
    return {1'b0, 8'(w)};
  endfunction

  task automatic run_scn(input logic [1:0] sc, input logic en, input int rel,
                         input int drop, input int total,
                         input string tk, input string ta, input string td);
    int b;
    bit skip;
    b = (rel > 3) ? rel : 3;
    while (!is_bound(b, sc)) b++;
    skip = (sc == 2'd0) && !en;
    rst_n = 0;
    sync_n = 0;
    @(posedge clk);
    @(posedge clk);
    #1;
    for (int c = 0; c < total; c++) begin
      item_t e;
      string t;
      logic [8:0] s;
      if (c > 0) begin
        @(posedge clk);
        #1;
      end
      subclass = sc;
      ilas_en = en;
      sync_n = (c >= rel) && !(drop >= 0 && c >= drop);
      tx_data = {8'(c * 3 + 1), 8'(c + 8'h40)};
      rst_n = 1;
      if (drop >= 0 && c > drop) begin
        e.oct = {LN{8'hBC}}; e.k = '1; t = "R8";
      end else if (c <= b) begin
        e.oct = {LN{8'hBC}}; e.k = '1; t = (c < rel) ? "R1" : tk;
      end else if (skip || c - b - 1 >= ALEN) begin
        e.oct = tx_data; e.k = '0; t = td;
      end else begin
        s = align_sym(c - b - 1);
        e.oct = {LN{s[7:0]}}; e.k = {LN{s[8]}}; t = ta;
      end
      exp_q.push_back(e);
      tag_q.push_back(t);
    end
    @(negedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R3 R5 R10: subclass 0 frame release, full alignment, then data
    run_scn(2'd0, 1'b1, 5, -1, 45, "R3", "R5", "R10");
    // R2: request already released at reset
    run_scn(2'd0, 1'b1, 0, -1, 10, "R2", "R5", "R10");
    // R6: alignment disabled in subclass 0
    run_scn(2'd0, 1'b0, 4, -1, 12, "R6", "R5", "R6");
    // R4: release just after a multiframe boundary waits for the very next one
    run_scn(2'd1, 1'b1, 8, -1, 56, "R4", "R5", "R9");
    // R7: subclass 2 sends alignment even with enable low
    run_scn(2'd2, 1'b0, 2, -1, 44, "R4", "R7", "R9");
    // R8: request drops during alignment
    run_scn(2'd1, 1'b1, 0, 20, 26, "R4", "R5", "R9");
    // R8: request drops during user data
    run_scn(2'd0, 1'b0, 0, 10, 16, "R2", "R5", "R9");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule